// File: doc/BRIEF.md
# Message Word Expansion Unit

This unit computes four expanded message words per operation for a 32-bit word hash schedule. Each operation takes three 128-bit operands, each holding four 32-bit lanes, and returns one 128-bit result. The expansion of four consecutive words is split into two lane-parallel steps, chosen by an opcode:

- **Partial step.** This produces partial terms for four lanes. The fourth lane leaves out the rotated term that depends on a word not yet known.
- **Finish step.** This combines the partial terms with older words. It then corrects the fourth lane using the first word it has just produced.

Software or a sequencer runs a partial step and then a finish step to obtain words 16..19 of a window, relative to the window's base word.

Operands and opcode are captured on a valid/ready handshake at the input. The result goes into a single output register, which is presented with its own valid/ready handshake. The register holds its value until the consumer takes it. A new operation may be accepted in the same cycle that the previous result is consumed.

Top module: `msgx_unit`

Notation: `rotl(x,n)` is a 32-bit left rotation by `n` mod 32. `P1(x) = x ^ rotl(x,15) ^ rotl(x,23)`. Lane k of a 128-bit vector is bits `[32k+31:32k]`.

## Requirements
- R1: With `op_sel`=0 (partial), for k = 0..2, result lane k = P1(a[k] ^ c[k] ^ rotl(b[k],15)).
- R2: With `op_sel`=0, result lane 3 = P1(a[3] ^ c[3]), with no term from operand b.
- R3: With `op_sel`=0, lane 3 of operand b (bits 127:96) has no effect on the result.
- R4: With `op_sel`=1 (finish), for k = 0..2, result lane k = rotl(b[k],7) ^ c[k] ^ a[k].
- R5: With `op_sel`=1, result lane 3 = (rotl(b[3],7) ^ c[3] ^ a[3]) ^ rotl(L0,6) ^ rotl(L0,15) ^ rotl(L0,30), where L0 is result lane 0.
- R6: Suppose words w[0..15] are loaded as follows. The partial step gets c={w3,w2,w1,w0}, a={w10,w9,w8,w7} and b={-,w15,w14,w13}. The finish step gets a=partial result, b={w6,w5,w4,w3} and c={w13,w12,w11,w10}. The finish result is then {w19,w18,w17,w16}, where w[j] = P1(w[j-16]^w[j-9]^rotl(w[j-3],15)) ^ rotl(w[j-13],7) ^ w[j-6].
- R7: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high after that edge and carries that operation's result.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` stays unchanged.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An edge that both consumes a result and accepts a new operation leaves `out_valid` high with the new result.
- R10: A rising edge with `rst_n` low clears `out_data` to zero and `out_valid` to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| op_sel | input | 1 | 0 = partial step, 1 = finish step |
| opnd_a | input | 128 | Operand a, four 32-bit lanes |
| opnd_b | input | 128 | Operand b, four 32-bit lanes |
| opnd_c | input | 128 | Operand c, four 32-bit lanes |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result, lane k in bits 32k+31:32k |

## Verification
Two functions can fall on the same edge: consuming the held result and accepting the next operation. The bench provokes this by stalling the consumer with a second request already pending. It checks that `in_ready` stays low and the data stays frozen during the stall. It then raises `out_ready` with the request still held, and expects the second result to appear immediately with `out_valid` still high. The arithmetic is judged in two ways. The first is walking single-bit sweeps over every operand bit for both opcodes, against lane formulas computed in the bench. The second is chained partial-then-finish runs compared with a directly computed word schedule.

// File: rtl/msgx_pkg.sv
// Package: shared widths, opcode encoding and word helpers for the
// message word expansion unit. Assumes 32-bit words, four lanes.
package msgx_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef enum logic {
        OP_PARTIAL = 1'b0,
        OP_FINISH  = 1'b1
    } msgx_op_e;

    // Left rotation of one word, count taken modulo the word width.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        int unsigned s;
        s = n % WORD_W;
        if (s == 0) return x;
        return (x << s) | (x >> (WORD_W - s));
    endfunction

    // Permutation used by the expansion: x ^ rotl15 ^ rotl23.
    function automatic word_t perm1(input word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction
endpackage

// File: rtl/msgx_partial.sv
// Module: msgx_partial
// Purely combinational partial step. Lanes below the last one mix in a
// rotated late word; the last lane omits it because that word is the
// first output of this very window and is not known yet.
// Assumes: late_w carries only the LANES-1 words that are used.
module msgx_partial
    import msgx_pkg::*;
#(
    parameter int ROT_LATE = 15,
    localparam int LATE_W  = (LANES - 1) * WORD_W
) (
    input  vec_t              early_w,
    input  vec_t              mid_w,
    input  logic [LATE_W-1:0] late_w,
    output vec_t              part_w
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k < LANES - 1) begin : g_full
            // Full lane: early ^ mid ^ rotated late word, then permute.
            always_comb begin
                part_w[k*WORD_W +: WORD_W] = perm1(
                    early_w[k*WORD_W +: WORD_W] ^ mid_w[k*WORD_W +: WORD_W] ^
                    rotl(late_w[k*WORD_W +: WORD_W], ROT_LATE));
            end
        end else begin : g_short
            // Last lane: rotated term unavailable, permute the rest.
            always_comb begin
                part_w[k*WORD_W +: WORD_W] = perm1(
                    early_w[k*WORD_W +: WORD_W] ^ mid_w[k*WORD_W +: WORD_W]);
            end
        end
    end
endmodule

// File: rtl/msgx_finish.sv
// Module: msgx_finish
// Purely combinational finish step. Each lane xors its partial term
// with a rotated old word and a near word; the last lane then adds the
// missing permutation terms built from the freshly computed lane 0.
// Assumes: partial terms come from msgx_partial of the same window.
module msgx_finish
    import msgx_pkg::*;
#(
    parameter int ROT_OLD = 7,
    parameter int FIX_R0  = 6,
    parameter int FIX_R1  = 15,
    parameter int FIX_R2  = 30
) (
    input  vec_t part_w,
    input  vec_t old_w,
    input  vec_t near_w,
    output vec_t done_w
);
    vec_t base_w;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Uncorrected lane value.
        always_comb begin
            base_w[k*WORD_W +: WORD_W] = rotl(old_w[k*WORD_W +: WORD_W], ROT_OLD) ^
                                         near_w[k*WORD_W +: WORD_W] ^
                                         part_w[k*WORD_W +: WORD_W];
        end
        if (k < LANES - 1) begin : g_pass
            // Lower lanes are final as computed.
            always_comb done_w[k*WORD_W +: WORD_W] = base_w[k*WORD_W +: WORD_W];
        end else begin : g_fix
            // Last lane: complete the permutation with lane 0's new word.
            always_comb begin
                done_w[k*WORD_W +: WORD_W] = base_w[k*WORD_W +: WORD_W] ^
                    rotl(base_w[WORD_W-1:0], FIX_R0) ^
                    rotl(base_w[WORD_W-1:0], FIX_R1) ^
                    rotl(base_w[WORD_W-1:0], FIX_R2);
            end
        end
    end
endmodule

// File: rtl/msgx_result_reg.sv
// Module: msgx_result_reg
// Single-entry result register with a valid flag. Loads on request,
// clears the flag when the consumer takes the result and nothing new
// is loaded. Assumes: load is only raised when the entry is free or
// being consumed in the same cycle.
module msgx_result_reg
    import msgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  vec_t load_data,
    input  logic out_ready,
    output logic out_valid,
    output vec_t out_data
);
    // Result storage and valid flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // A load always yields a presented result on the next cycle.
    p_load_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);

    // A stalled result stays presented and unchanged.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));

    // Valid only drops after the consumer took the result.
    p_drop_needs_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_valid) && $past(rst_n)) |-> $past(out_ready));
endmodule

// File: rtl/msgx_unit.sv
// Module: msgx_unit (top)
// Message word expansion unit: partial and finish steps computed in
// parallel, result selected by opcode and registered on acceptance.
// Assumes: operands and opcode are stable while in_valid is high.
module msgx_unit
    import msgx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         op_sel,
    input  logic [127:0] opnd_a,
    input  logic [127:0] opnd_b,
    input  logic [127:0] opnd_c,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [127:0] out_data
);
    localparam int LATE_W = (LANES - 1) * WORD_W;

    vec_t     part_res;
    vec_t     fin_res;
    vec_t     sel_res;
    logic     accept;
    msgx_op_e op_e;

    // Partial step: c = oldest words, a = middle words, b = latest words.
    msgx_partial #(.ROT_LATE(15)) u_partial (
        .early_w (opnd_c),
        .mid_w   (opnd_a),
        .late_w  (opnd_b[LATE_W-1:0]),
        .part_w  (part_res)
    );

    // Finish step: a = partial terms, b = old words, c = near words.
    msgx_finish #(.ROT_OLD(7), .FIX_R0(6), .FIX_R1(15), .FIX_R2(30)) u_finish (
        .part_w (opnd_a),
        .old_w  (opnd_b),
        .near_w (opnd_c),
        .done_w (fin_res)
    );

    // Handshake: free when empty or being emptied this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Opcode decode and result select.
    always_comb begin
        op_e    = msgx_op_e'(op_sel);
        sel_res = (op_e == OP_FINISH) ? fin_res : part_res;
    end

    msgx_result_reg u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (sel_res),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Inverse check of a finish lane 0: undoing the mix recovers operand a.
    always_ff @(posedge clk) begin
        if (rst_n && accept && op_sel) begin
            p_fin_lane0_inverse_r4: assert ((sel_res[31:0] ^ rotl(opnd_b[31:0], 7) ^
                                             opnd_c[31:0]) == opnd_a[31:0]);
        end
    end

    // Stalled output blocks new operations.
    p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !accept);
endmodule

// File: tb/msgx_unit_bench.sv
module msgx_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic         op_sel;
    logic [127:0] opnd_a, opnd_b, opnd_c;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_data;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgx_unit u_msgx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        int s = n % 32;
        return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
    endfunction

    function automatic logic [31:0] pp(input logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    function automatic logic [31:0] ln(input logic [127:0] v, input int k);
        return v[k*32 +: 32];
    endfunction

    // Expected partial result from R1 and R2 (b lane 3 unused, R3).
    function automatic logic [127:0] exp_part(input logic [127:0] a, b, c);
        logic [127:0] r;
        for (int k = 0; k < 3; k++)
            r[k*32 +: 32] = pp(ln(a,k) ^ ln(c,k) ^ rl(ln(b,k), 15));
        r[127:96] = pp(ln(a,3) ^ ln(c,3));
        return r;
    endfunction

    // Expected finish result from R4 and R5.
    function automatic logic [127:0] exp_fin(input logic [127:0] a, b, c);
        logic [127:0] r;
        logic [31:0]  l0;
        for (int k = 0; k < 4; k++)
            r[k*32 +: 32] = rl(ln(b,k), 7) ^ ln(c,k) ^ ln(a,k);
        l0 = r[31:0];
        r[127:96] = r[127:96] ^ rl(l0, 6) ^ rl(l0, 15) ^ rl(l0, 30);
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    endtask

    // One accepted operation with consumer ready; result read after edge.
    task automatic run_op(input logic op, input logic [127:0] a, b, c,
                          output logic [127:0] res);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; opnd_c = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        res = out_data;
        if (!out_valid) check("R7 out_valid after accept", {127'd0, out_valid}, 128'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_miss++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [127:0] res, base, a, b, c, e1, e2;
        logic [31:0]  w [0:19];
        string        tag;

        rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0; out_ready = 1'b1;
        opnd_a = '0; opnd_b = '0; opnd_c = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset data", out_data, 128'd0);
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        check("R9 ready when empty", {127'd0, in_ready}, 128'd1);

        // Walking single-bit sweep over every operand bit, both steps,
        // on a zero base and on a fixed dense base.
        for (int pass = 0; pass < 2; pass++) begin
            base = (pass == 0) ? 128'd0 : 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
            for (int op = 0; op < 2; op++) begin
                for (int which = 0; which < 3; which++) begin
                    for (int bitn = 0; bitn < 128; bitn++) begin
                        a = base; b = ~base; c = {base[63:0], base[127:64]};
                        if (which == 0) a[bitn] = ~a[bitn];
                        else if (which == 1) b[bitn] = ~b[bitn];
                        else c[bitn] = ~c[bitn];
                        run_op(op[0], a, b, c, res);
                        if (op == 0) begin
                            tag = (which == 1 && bitn >= 96) ? "R3 b lane3 ignored" :
                                  (bitn >= 96) ? "R2 partial lane3" : "R1 partial lanes";
                            check(tag, res, exp_part(a, b, c));
                        end else begin
                            tag = "R4 R5 finish lanes";
                            check(tag, res, exp_fin(a, b, c));
                        end
                    end
                end
            end
        end

        // R3 direct: partial result equal with b lane 3 all ones vs zero.
        run_op(1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h0, 128'hABCD, e1);
        run_op(1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
               {32'hFFFF_FFFF, 96'h0}, 128'hABCD, e2);
        check("R3 b lane3 no effect", e2, e1);

        // R6: chained steps against a directly computed schedule.
        for (int t = 0; t < 40; t++) begin
            for (int j = 0; j < 16; j++) w[j] = $urandom();
            for (int j = 16; j < 20; j++)
                w[j] = pp(w[j-16] ^ w[j-9] ^ rl(w[j-3], 15)) ^ rl(w[j-13], 7) ^ w[j-6];
            run_op(1'b0, {w[10], w[9], w[8], w[7]}, {$urandom(), w[15], w[14], w[13]},
                   {w[3], w[2], w[1], w[0]}, res);
            run_op(1'b1, res, {w[6], w[5], w[4], w[3]}, {w[13], w[12], w[11], w[10]}, res);
            check("R6 chained schedule", res, {w[19], w[18], w[17], w[16]});
        end

        // R8/R9: stall, pending request, then consume and accept together.
        a = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
        @(negedge clk);
        out_ready = 1'b0;
        run_op(1'b0, a, a, a, res);
        e1 = exp_part(a, a, a);
        check("R7 stalled first result", res, e1);
        b = ~a;
        in_valid = 1'b1; op_sel = 1'b1; opnd_a = b; opnd_b = a; opnd_c = b;
        e2 = exp_fin(b, a, b);
        repeat (3) begin
            @(negedge clk);
            check("R8 ready low while stalled", {127'd0, in_ready}, 128'd0);
            check("R8 data held while stalled", out_data, e1);
        end
        out_ready = 1'b1;
        #1;
        check("R9 ready when consumer ready", {127'd0, in_ready}, 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 back-to-back valid", {127'd0, out_valid}, 128'd1);
        check("R9 back-to-back data", out_data, e2);
        @(negedge clk);
        check("R7 valid drops after take", {127'd0, out_valid}, 128'd0);

        // R10: reset in mid-run while a result is held.
        out_ready = 1'b0;
        run_op(1'b1, a, b, a, res);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 midrun data", out_data, 128'd0);
        check("R10 midrun valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        report();
    end
endmodule